// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block interprets the write cycles that a host issues to a parallel NOR flash using the classic unlock-prefixed command set. Each write carries a byte address and a data word. The block first divides the byte address by the configured bus width to get a word address. It then follows the two-write unlock prefix and acts on the command byte that comes next. The result is a read mode: array mode, identification mode or query mode. In the identification and query modes the block itself supplies the read data. In array mode it stays silent, so the storage array, which lies outside this block, can answer.

Command matching uses only the low 11 bits of the word address. The block applies the same 11-bit mask to the two configured unlock locations. As a result, short unlock addresses (0x555 / 0x2AA) and long ones (0x5555 / 0x2AAA) select the same locations. Register reads in identification and query modes decode the full word address, not the masked one.

Top module: `nor_cmd_decoder`

## Requirements
- R1: Out of synchronous reset the mode is array (code 2'b00) and the sequencer is idle. A lone second-unlock write followed by an autoselect write does not leave array mode.
- R2: The word address is the byte address shifted right by 0, 1 or 2. The shift is chosen by `width_sel`: 2'b00 selects 8-bit (shift 0), 2'b01 selects 16-bit (shift 1), 2'b10 selects 32-bit (shift 2), and the reserved value 2'b11 behaves as 8-bit. Both write and read addresses are scaled this way.
- R3: Command addresses are compared on word-address bits [10:0] only. The configured unlock locations (defaults 0x5555 and 0x2AAA) are masked to 11 bits as well, so 0x555, 0x5555 and 0xD555 all hit the first location, and 0x2AA, 0x2AAA and 0xAAAA all hit the second.
- R4: Writing low byte 0xAA to the first location, then 0x55 to the second, then 0x90 to the first enters identification mode (code 2'b01). Only the low data byte is compared.
- R5: A write that does not continue the prefix returns the sequencer to idle and leaves the mode unchanged. A wrong data byte and a wrong address are both breaks, and a break is not counted as the start of a new prefix.
- R6: A write whose low byte is 0xF0 returns to array mode and idles the sequencer, from any mode and at any address, including partway through the prefix.
- R7: A write of 0x98 whose masked word address is 0x055 enters query mode (code 2'b10) from any state and idles the sequencer.
- R8: In identification mode, full word address 0 reads 0x00BF, word 1 reads 0x236D, and every other word (including 0x800) reads 0.
- R9: In query mode, full word addresses 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059, and every other word reads 0.
- R10: `rd_sel` is high exactly when the mode is identification or query. In array mode `rd_data` is 0.
- R11: The mode changes only on a clock edge at which `wr_en` is high, one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one bus write per cycle it is high |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; the low byte is the command |
| width_sel | input | 2 | Bus width: 00 8-bit, 01 16-bit, 10 32-bit, 11 as 8-bit |
| rd_addr | input | ADDR_W | Byte address of the current read |
| mode | output | 2 | 00 array, 01 identification, 10 query |
| rd_sel | output | 1 | High when this block drives the read data |
| rd_data | output | DATA_W | Register read data, 0 in array mode |

## Verification
The unlock and command sequences are swept over every width setting and three address forms: short, long, and long with high bits set. Because every form must give the same result, this separates correct 11-bit masking and width scaling from an unmasked or wrongly shifted comparison. Broken sequences are applied on purpose: wrong address, wrong data, near-miss address, and a reset byte partway through the prefix. These show that a break idles the sequencer without touching the mode. Identification reads at word 0x800 and query reads just past the table separate full-address decoding from masked decoding on the read side.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int CMP_BITS = 11;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'b00,
        MODE_IDENT = 2'b01,
        MODE_QUERY = 2'b10
    } flash_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'b00,
        SEQ_GOT_AA = 2'b01,
        SEQ_GOT_55 = 2'b10
    } seq_stage_e;

    localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_RESET   = 8'hF0;

    localparam logic [CMP_BITS-1:0] QUERY_KEY = 11'h055;

    typedef struct packed {
        logic                valid;
        logic [CMP_BITS-1:0] key;
        logic [7:0]          cmd;
    } wr_cycle_t;

    function automatic logic [1:0] width_shift(input logic [1:0] sel);
        case (sel)
            2'b01:   return 2'd1;
            2'b10:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/nor_addr_scaler.sv
module nor_addr_scaler
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [1:0]        width_sel,
    output logic [ADDR_W-1:0] word_addr
);

    always_comb begin
        case (width_shift(width_sel))
            2'd1:    word_addr = byte_addr >> 1;
            2'd2:    word_addr = byte_addr >> 2;
            default: word_addr = byte_addr;
        endcase
    end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int UNLOCK_A = 32'h5555,
    parameter int UNLOCK_B = 32'h2AAA
) (
    input  logic        clk,
    input  logic        rst,
    input  wr_cycle_t   wcyc,
    output flash_mode_e mode_q,
    output seq_stage_e  stage_q
);

    localparam logic [CMP_BITS-1:0] KEY_A = CMP_BITS'(UNLOCK_A & ((1 << CMP_BITS) - 1));
    localparam logic [CMP_BITS-1:0] KEY_B = CMP_BITS'(UNLOCK_B & ((1 << CMP_BITS) - 1));

    flash_mode_e mode_d;
    seq_stage_e  stage_d;
    logic        hit_a, hit_b;

    assign hit_a = (wcyc.key == KEY_A);
    assign hit_b = (wcyc.key == KEY_B);

    always_comb begin
        mode_d  = mode_q;
        stage_d = stage_q;
        if (wcyc.valid) begin
            if (wcyc.cmd == CMD_RESET) begin
                mode_d  = MODE_ARRAY;
                stage_d = SEQ_IDLE;
            end else if (wcyc.cmd == CMD_QUERY && wcyc.key == QUERY_KEY) begin
                mode_d  = MODE_QUERY;
                stage_d = SEQ_IDLE;
            end else begin
                case (stage_q)
                    SEQ_IDLE:
                        stage_d = (hit_a && wcyc.cmd == CMD_UNLOCK1) ? SEQ_GOT_AA : SEQ_IDLE;
                    SEQ_GOT_AA:
                        stage_d = (hit_b && wcyc.cmd == CMD_UNLOCK2) ? SEQ_GOT_55 : SEQ_IDLE;
                    SEQ_GOT_55: begin
                        stage_d = SEQ_IDLE;
                        if (hit_a && wcyc.cmd == CMD_AUTOSEL)
                            mode_d = MODE_IDENT;
                    end
                    default:
                        stage_d = SEQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_ARRAY;
            stage_q <= SEQ_IDLE;
        end else begin
            mode_q  <= mode_d;
            stage_q <= stage_d;
        end
    end

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mode_q == MODE_ARRAY && stage_q == SEQ_IDLE));

    // R6
    a_r6_reset_cmd: assert property (@(posedge clk) disable iff (rst)
        (wcyc.valid && wcyc.cmd == CMD_RESET) |=> (mode_q == MODE_ARRAY && stage_q == SEQ_IDLE));

    // R11
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !wcyc.valid |=> $stable(mode_q));

    // R4
    a_r4_ident_needs_prefix: assert property (@(posedge clk) disable iff (rst)
        (wcyc.valid && stage_q != SEQ_GOT_55 && mode_q != MODE_IDENT) |=> (mode_q != MODE_IDENT));

    // R5
    a_r5_break_idles: assert property (@(posedge clk) disable iff (rst)
        (wcyc.valid && stage_q == SEQ_GOT_AA && !(hit_b && wcyc.cmd == CMD_UNLOCK2))
        |=> (stage_q == SEQ_IDLE));

    // R7
    a_r7_query_entry: assert property (@(posedge clk) disable iff (rst)
        (wcyc.valid && wcyc.cmd == CMD_QUERY && wcyc.key == QUERY_KEY)
        |=> (mode_q == MODE_QUERY && stage_q == SEQ_IDLE));

endmodule

// File: rtl/nor_reg_readout.sv
module nor_reg_readout
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W = 20,
    parameter int          DATA_W = 16,
    parameter logic [15:0] MFR_ID = 16'h00BF,
    parameter logic [15:0] DEV_ID = 16'h236D
) (
    input  flash_mode_e       mode,
    input  logic [ADDR_W-1:0] word_addr,
    output logic              rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    function automatic logic [DATA_W-1:0] query_word(input logic [ADDR_W-1:0] idx);
        case (idx)
            ADDR_W'(16'h10): return DATA_W'(8'h51);
            ADDR_W'(16'h11): return DATA_W'(8'h52);
            ADDR_W'(16'h12): return DATA_W'(8'h59);
            default:         return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ident_word(input logic [ADDR_W-1:0] idx);
        if (idx == ADDR_W'(0))      return DATA_W'(MFR_ID);
        else if (idx == ADDR_W'(1)) return DATA_W'(DEV_ID);
        else                        return '0;
    endfunction

    always_comb begin
        rd_sel  = 1'b0;
        rd_data = '0;
        case (mode)
            MODE_IDENT: begin
                rd_sel  = 1'b1;
                rd_data = ident_word(word_addr);
            end
            MODE_QUERY: begin
                rd_sel  = 1'b1;
                rd_data = query_word(word_addr);
            end
            default: begin
                rd_sel  = 1'b0;
                rd_data = '0;
            end
        endcase
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter int          DATA_W   = 16,
    parameter int          UNLOCK_A = 32'h5555,
    parameter int          UNLOCK_B = 32'h2AAA,
    parameter logic [15:0] MFR_ID   = 16'h00BF,
    parameter logic [15:0] DEV_ID   = 16'h236D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        width_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        mode,
    output logic              rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    localparam int CMD_W = 8;

    logic [ADDR_W-1:0] wr_word, rd_word;
    wr_cycle_t         wcyc;
    flash_mode_e       mode_q;
    seq_stage_e        stage_q;

    nor_addr_scaler #(.ADDR_W(ADDR_W)) u_wr_scale (
        .byte_addr (wr_addr),
        .width_sel (width_sel),
        .word_addr (wr_word)
    );

    nor_addr_scaler #(.ADDR_W(ADDR_W)) u_rd_scale (
        .byte_addr (rd_addr),
        .width_sel (width_sel),
        .word_addr (rd_word)
    );

    // High word-address bits and high data bits take no part in command decoding.
    logic unused_wr_hi;
    generate
        if (DATA_W > CMD_W) begin : g_wide_data
            assign unused_wr_hi = ^{wr_word[ADDR_W-1:CMP_BITS], wr_data[DATA_W-1:CMD_W]};
        end else begin : g_byte_data
            assign unused_wr_hi = ^wr_word[ADDR_W-1:CMP_BITS];
        end
    endgenerate

    assign wcyc.valid = wr_en;
    assign wcyc.key   = wr_word[CMP_BITS-1:0];
    assign wcyc.cmd   = wr_data[CMD_W-1:0];

    nor_seq_fsm #(.UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wcyc    (wcyc),
        .mode_q  (mode_q),
        .stage_q (stage_q)
    );

    nor_reg_readout #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_rd (
        .mode      (mode_q),
        .word_addr (rd_word),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data)
    );

    assign mode = mode_q;

    // R10
    a_r10_array_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |-> (!rd_sel && rd_data == '0));

endmodule

// File: tb/sim_nor_cmd_decoder.sv
module sim_nor_cmd_decoder;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        width_sel = 2'b01;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [1:0]        mode;
    logic              rd_sel;
    logic [DATA_W-1:0] rd_data;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    nor_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .width_sel(width_sel), .rd_addr(rd_addr), .mode(mode), .rd_sel(rd_sel),
        .rd_data(rd_data)
    );

    function automatic int shamt(input logic [1:0] sel);
        return (sel == 2'b01) ? 1 : (sel == 2'b10) ? 2 : 0;
    endfunction

    function automatic logic [ADDR_W-1:0] to_byte(input int word);
        return ADDR_W'(word << shamt(width_sel));
    endfunction

    task automatic bus_write(input int word, input int data);
        @(negedge clk);
        wr_addr = to_byte(word);
        wr_data = DATA_W'(data);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic chk_mode(input logic [1:0] exp, input string req);
        vectors++;
        if (mode !== exp) begin
            miscompares++;
            $display("FAIL %s mode actual=%0d expected=%0d (width_sel=%0d)", req, mode, exp, width_sel);
        end
    endtask

    task automatic chk_read(input int word, input logic exp_sel, input int exp, input string req);
        rd_addr = to_byte(word);
        #1;
        vectors++;
        if (rd_sel !== exp_sel || rd_data !== DATA_W'(exp)) begin
            miscompares++;
            $display("FAIL %s read word %0h actual=%0b/%04h expected=%0b/%04h",
                     req, word, rd_sel, rd_data, exp_sel, DATA_W'(exp));
        end
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int ua [3];
        int ub [3];
        ua = '{32'h555, 32'h5555, 32'hD555};
        ub = '{32'h2AA, 32'h2AAA, 32'hAAAA};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state and idle sequencer
        chk_mode(2'b00, "R1");
        chk_read(0, 1'b0, 0, "R1");
        bus_write(32'h2AA, 32'h55);
        bus_write(32'h555, 32'h90);
        chk_mode(2'b00, "R1");

        for (int sel = 0; sel < 4; sel++) begin
            width_sel = 2'(sel);
            for (int f = 0; f < 3; f++) begin
                // R2/R3/R4: unlock + autoselect in each width and address form
                bus_write(0, 32'hF0);
                chk_mode(2'b00, "R6");
                bus_write(ua[f], 32'hAA);
                bus_write(ub[f], 32'h55);
                chk_mode(2'b00, "R4");
                bus_write(ua[f], 32'h1290);
                chk_mode(2'b01, "R3");
                repeat (3) @(negedge clk);
                chk_mode(2'b01, "R11");
                // R8: full-address identification reads
                chk_read(0, 1'b1, 32'h00BF, "R8");
                chk_read(1, 1'b1, 32'h236D, "R8");
                chk_read(2, 1'b1, 0, "R8");
                chk_read(32'h800, 1'b1, 0, "R8");
                // R5: break in ident mode keeps mode
                bus_write(ua[f], 32'hAA);
                bus_write(ua[f], 32'h55);
                chk_mode(2'b01, "R5");
                // R6: reset byte leaves ident mode
                bus_write(32'h123, 32'hF0);
                chk_mode(2'b00, "R6");
                chk_read(0, 1'b0, 0, "R10");
                // R5: wrong address then autoselect does nothing
                bus_write(ua[f], 32'hAA);
                bus_write(ua[f], 32'h55);
                bus_write(ua[f], 32'h90);
                chk_mode(2'b00, "R5");
                // R5: wrong data
                bus_write(ua[f], 32'hAA);
                bus_write(ub[f], 32'h54);
                bus_write(ua[f], 32'h90);
                chk_mode(2'b00, "R5");
                // R3: near-miss address
                bus_write(32'h556, 32'hAA);
                bus_write(ub[f], 32'h55);
                bus_write(32'h556, 32'h90);
                chk_mode(2'b00, "R3");
                // R6: reset byte mid-prefix
                bus_write(ua[f], 32'hAA);
                bus_write(ub[f], 32'h55);
                bus_write(ua[f], 32'hF0);
                bus_write(ua[f], 32'h90);
                chk_mode(2'b00, "R6");
                // R7: query entry, high bits masked
                bus_write((f == 0) ? 32'h55 : 32'h855, 32'h98);
                chk_mode(2'b10, "R7");
                chk_read(32'h10, 1'b1, 32'h51, "R9");
                chk_read(32'h11, 1'b1, 32'h52, "R9");
                chk_read(32'h12, 1'b1, 32'h59, "R9");
                chk_read(32'h13, 1'b1, 0, "R9");
                chk_read(32'h810, 1'b1, 0, "R9");
                // R7: query from partway through prefix, then prefix idles
                bus_write(32'hF0 - 32'hF0, 32'hF0);
                bus_write(ua[f], 32'hAA);
                bus_write(32'h55, 32'h98);
                chk_mode(2'b10, "R7");
                bus_write(ub[f], 32'h55);
                bus_write(ua[f], 32'h90);
                chk_mode(2'b10, "R7");
                bus_write(0, 32'hF0);
                chk_mode(2'b00, "R6");
            end
        end

        // R2: reserved width code behaves as byte: raw byte address matches
        width_sel = 2'b11;
        @(negedge clk);
        wr_addr = ADDR_W'(32'h555); wr_data = 16'hAA; wr_en = 1'b1;
        @(negedge clk);
        wr_addr = ADDR_W'(32'h2AA); wr_data = 16'h55;
        @(negedge clk);
        wr_addr = ADDR_W'(32'h555); wr_data = 16'h90;
        @(negedge clk);
        wr_en = 1'b0;
        chk_mode(2'b01, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule